// File: doc/BRIEF.md
# DMA Controller Programming Port

This block is the byte-wide register front end of a four-channel DMA controller. A host reaches it through an 8-bit I/O port with a 4-bit offset. Through that port the host loads each channel's 16-bit start address and 16-bit transfer count, sets each channel's operating mode, masks or unmasks channels, and reads back terminal-count status. The transfer engine beside it takes the per-channel base values, the mode fields and the mask bits. It returns terminal-count pulses, and this block latches them until software reads them.

Every 16-bit register is reached through one byte-wide port, so a single byte pointer, shared by all channels, picks the low or the high half. Every address or count access flips the pointer. A write to a dedicated offset returns it to the low half. Masks can be changed one channel at a time or all four at once.

Offset map: 2n is the address of channel n and 2n+1 its count (n = 0..3). Offset 8 reads status. Offset 9 writes the single-channel mask, offset 10 writes the mode, offset 11 resets the byte pointer and offset 12 writes the all-channel mask.

Top module: `dmac_regif`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer selects the low byte, all base values and mode fields are 0, no load strobe is active and the status read returns 0.
- R2: A write at offset 2n or 2n+1 stores the data byte in the low half of that channel's address or count when the pointer is low, and in the high half when it is high. A high-byte write pulses chan_load[n] for exactly one cycle, in the cycle after the write.
- R3: A read at offset 2n or 2n+1 returns, on io_rdata in the same cycle, the low byte of that register when the pointer is low and the high byte when it is high.
- R4: Each read or write at offsets 0 to 7 flips the byte pointer. The one pointer is shared by all eight registers.
- R5: A write of any data byte at offset 11 sets the pointer to low, whatever its previous state.
- R6: A write at offset 9 uses data bits 1:0 as the channel and bit 2 as the new mask value (1 masks, 0 unmasks). Only that channel's mask bit changes.
- R7: A write at offset 12 loads data bits 3:0 into mask bits 3:0 (bit n for channel n). Writing 0x0F masks every channel.
- R8: A write at offset 10 uses data bits 1:0 as the channel and stores data bits 7:2 in mode_cfg[6n+5:6n] for that channel only. Bits 3:2 are the direction, bit 4 auto-initialize, bit 5 address decrement and bits 7:6 the mode (01 single, 11 cascade).
- R9: A pulse on tc_in[n] sets status flag n, which holds until it is read. A read at offset 8 returns the flags in bits 3:0, with bits 7:4 zero.
- R10: A status read clears the flags it returned. A tc_in pulse in the same cycle as that read is kept, and it appears on the next status read.
- R11: Reads at offsets 9 to 15 return 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid during the io_rd cycle |
| tc_in | input | 4 | Terminal-count pulses from the engine |
| chan_mask | output | 4 | Mask bit per channel |
| mode_cfg | output | 24 | Six mode bits per channel |
| base_addr | output | 64 | 16-bit base address per channel |
| base_count | output | 64 | 16-bit base count per channel |
| chan_load | output | 4 | One-cycle strobe after a high-byte write |

## Verification
Read data is combinational: the bench drives a read on a falling edge and samples io_rdata a moment later, before the rising edge at which the pointer flips or the status flags clear. Mask, mode and base values, and the load strobe, are registered. They change on the rising edge that accepts the write and are sampled on the falling edge after it. The strobe is checked in that same half-cycle window, and every access is followed by an idle cycle so that the strobe's return to zero is also observed. The bench model advances its pointer and flags only after it has compared a read, so each expected value comes from the state before the access.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH     = 4;
  localparam int BYTE_W  = 8;
  localparam int REG_W   = 2 * BYTE_W;
  localparam int OFS_W   = 4;
  localparam int MODE_W  = 6;
  localparam int CH_W    = $clog2(NCH);

  localparam logic [OFS_W-1:0] OFS_STATUS = 4'd8;
  localparam logic [OFS_W-1:0] OFS_SMASK  = 4'd9;
  localparam logic [OFS_W-1:0] OFS_MODE   = 4'd10;
  localparam logic [OFS_W-1:0] OFS_PTRCLR = 4'd11;
  localparam logic [OFS_W-1:0] OFS_AMASK  = 4'd12;
endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic clear,
  output logic hi
);
  logic ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clear)       ptr_d = 1'b0;
    else if (access) ptr_d = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end

  assign hi = ptr_q;

  assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hi);
  assert_ptr_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !clear) |=> (hi != $past(hi)));
endmodule

// File: rtl/dmac_mask.sv
module dmac_mask
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_we,
  input  logic              all_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    mask
);
  logic [NCH-1:0] mask_q, mask_d;
  logic [CH_W-1:0] sel;

  assign sel = wdata[CH_W-1:0];

  always_comb begin
    mask_d = mask_q;
    if (all_we)         mask_d = wdata[NCH-1:0];
    else if (single_we) mask_d[sel] = wdata[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  assign mask = mask_q;

  assert_single_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_we && !all_we) |=>
      (((mask ^ $past(mask)) & ~(NCH'(1) << $past(sel))) == '0));
  assert_all_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_we |=> (mask == $past(wdata[NCH-1:0])));
endmodule

// File: rtl/dmac_tcstat.sv
module dmac_tcstat
  import dmac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_clr,
  input  logic [NCH-1:0] tc_in,
  output logic [NCH-1:0] flags
);
  logic [NCH-1:0] flags_q, flags_d;

  always_comb begin
    if (rd_clr) flags_d = tc_in;
    else        flags_d = flags_q | tc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  assert_clear_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (flags == $past(tc_in)));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              cnt_we,
  input  logic              hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mode_we,
  output logic [REG_W-1:0]  base_addr,
  output logic [REG_W-1:0]  base_cnt,
  output logic [MODE_W-1:0] mode,
  output logic              load
);
  logic [REG_W-1:0]  addr_q, addr_d, cnt_q, cnt_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              load_q, load_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (addr_we) begin
      if (hi) addr_d[REG_W-1:BYTE_W] = wdata;
      else    addr_d[BYTE_W-1:0]     = wdata;
    end
    if (cnt_we) begin
      if (hi) cnt_d[REG_W-1:BYTE_W] = wdata;
      else    cnt_d[BYTE_W-1:0]     = wdata;
    end
    if (mode_we) mode_d = wdata[BYTE_W-1:2];
    load_d = (addr_we || cnt_we) && hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      load_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      load_q <= load_d;
    end
  end

  assign base_addr = addr_q;
  assign base_cnt  = cnt_q;
  assign mode      = mode_q;
  assign load      = load_q;

  assert_load_after_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_we || cnt_we) && hi) |=> load);
  assert_low_keeps_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && !hi) |=> (base_addr[REG_W-1:BYTE_W] == $past(base_addr[REG_W-1:BYTE_W])));
  assert_mode_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode));
endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
  import dmac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [OFS_W-1:0]      io_addr,
  input  logic [BYTE_W-1:0]     io_wdata,
  output logic [BYTE_W-1:0]     io_rdata,
  input  logic [NCH-1:0]        tc_in,
  output logic [NCH-1:0]        chan_mask,
  output logic [NCH*MODE_W-1:0] mode_cfg,
  output logic [NCH*REG_W-1:0]  base_addr,
  output logic [NCH*REG_W-1:0]  base_count,
  output logic [NCH-1:0]        chan_load
);
  localparam int PAIR_OFS = 2 * NCH;

  logic            in_pair, pair_wr, pair_rd, hi;
  logic [CH_W-1:0] pair_ch;
  logic            pair_is_cnt;
  logic            stat_rd, smask_we, amask_we, mode_we, ptr_clr;
  logic [NCH-1:0]  flags;
  logic [REG_W-1:0] addr_arr [NCH];
  logic [REG_W-1:0] cnt_arr  [NCH];

  assign in_pair     = (32'(io_addr) < PAIR_OFS);
  assign pair_wr     = io_wr && in_pair;
  assign pair_rd     = io_rd && !io_wr && in_pair;
  assign pair_ch     = io_addr[CH_W:1];
  assign pair_is_cnt = io_addr[0];
  assign stat_rd     = io_rd && !io_wr && (io_addr == OFS_STATUS);
  assign smask_we    = io_wr && (io_addr == OFS_SMASK);
  assign mode_we     = io_wr && (io_addr == OFS_MODE);
  assign ptr_clr     = io_wr && (io_addr == OFS_PTRCLR);
  assign amask_we    = io_wr && (io_addr == OFS_AMASK);

  dmac_byteptr u_ptr (
    .clk(clk), .rst_n(rst_n),
    .access(pair_wr || pair_rd), .clear(ptr_clr), .hi(hi)
  );

  dmac_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .single_we(smask_we), .all_we(amask_we),
    .wdata(io_wdata), .mask(chan_mask)
  );

  dmac_tcstat u_stat (
    .clk(clk), .rst_n(rst_n),
    .rd_clr(stat_rd), .tc_in(tc_in), .flags(flags)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel = (pair_ch == CH_W'(n));
    dmac_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .addr_we(pair_wr && sel && !pair_is_cnt),
      .cnt_we(pair_wr && sel && pair_is_cnt),
      .hi(hi),
      .wdata(io_wdata),
      .mode_we(mode_we && (io_wdata[CH_W-1:0] == CH_W'(n))),
      .base_addr(addr_arr[n]),
      .base_cnt(cnt_arr[n]),
      .mode(mode_cfg[n*MODE_W +: MODE_W]),
      .load(chan_load[n])
    );
    assign base_addr[n*REG_W +: REG_W]  = addr_arr[n];
    assign base_count[n*REG_W +: REG_W] = cnt_arr[n];
  end

  always_comb begin
    logic [REG_W-1:0] word;
    word = pair_is_cnt ? cnt_arr[pair_ch] : addr_arr[pair_ch];
    io_rdata = '0;
    if (pair_rd)      io_rdata = hi ? word[REG_W-1:BYTE_W] : word[BYTE_W-1:0];
    else if (stat_rd) io_rdata = BYTE_W'(flags);
  end

  assert_onehot_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_load));
  assert_unmapped_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && (io_addr > OFS_STATUS)) |-> (io_rdata == '0));
endmodule

// File: tb/tb_dmac_regif.sv
module tb_dmac_regif;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, io_wr, io_rd;
  logic [3:0]  io_addr, tc_in, chan_mask, chan_load;
  logic [7:0]  io_wdata, io_rdata;
  logic [23:0] mode_cfg;
  logic [63:0] base_addr, base_count;

  dmac_regif dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .tc_in(tc_in), .chan_mask(chan_mask), .mode_cfg(mode_cfg),
    .base_addr(base_addr), .base_count(base_count), .chan_load(chan_load)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic        m_ptr;
  logic [3:0]  m_mask, m_flags, m_load;
  logic [15:0] m_adr [4];
  logic [15:0] m_cnt [4];
  logic [5:0]  m_mode [4];

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [3:0] a);
    logic [15:0] w;
    if (a < 8) begin
      w = a[0] ? m_cnt[a[2:1]] : m_adr[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 8) return {4'b0, m_flags};
    return 8'h00;
  endfunction

  function automatic logic [63:0] pack16(input bit cnt);
    logic [63:0] v;
    for (int n = 0; n < 4; n++) v[n*16 +: 16] = cnt ? m_cnt[n] : m_adr[n];
    return v;
  endfunction

  function automatic logic [23:0] packmode();
    logic [23:0] v;
    for (int n = 0; n < 4; n++) v[n*6 +: 6] = m_mode[n];
    return v;
  endfunction

  task automatic compare_all(input string tag);
    check({tag, " R6 mask"}, 64'(chan_mask), 64'(m_mask));
    check({tag, " R2 addr"}, base_addr, pack16(0));
    check({tag, " R2 count"}, base_count, pack16(1));
    check({tag, " R8 mode"}, 64'(mode_cfg), 64'(packmode()));
    check({tag, " R2 load"}, 64'(chan_load), 64'(m_load));
  endtask

  // one access, then an idle cycle; expected state from the model
  task automatic op(input bit wr, input bit rd, input logic [3:0] a,
                    input logic [7:0] d, input logic [3:0] tc, input string tag);
    logic [7:0] got;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; tc_in = tc;
    #1 got = io_rdata;
    if (rd) check({tag, (a < 8) ? " R3 rd" : (a == 8) ? " R9 status" : " R11 unmapped"},
                  64'(got), 64'(model_rd(a)));
    m_load = 4'h0;
    if (wr) begin
      if (a < 8) begin
        if (m_ptr) begin
          if (a[0]) m_cnt[a[2:1]][15:8] = d; else m_adr[a[2:1]][15:8] = d;
          m_load = 4'(1) << a[2:1];
        end else begin
          if (a[0]) m_cnt[a[2:1]][7:0] = d; else m_adr[a[2:1]][7:0] = d;
        end
        m_ptr = ~m_ptr;
      end else if (a == 9)  m_mask[d[1:0]] = d[2];
      else if (a == 10)     m_mode[d[1:0]] = d[7:2];
      else if (a == 11)     m_ptr = 1'b0;
      else if (a == 12)     m_mask = d[3:0];
      m_flags = m_flags | tc;
    end else if (rd) begin
      if (a < 8) m_ptr = ~m_ptr;
      if (a == 8) m_flags = tc; else m_flags = m_flags | tc;
    end else m_flags = m_flags | tc;
    @(negedge clk);
    io_wr = 0; io_rd = 0; tc_in = 0;
    compare_all(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0; tc_in = 0;
    rst_n = 0;
    m_ptr = 0; m_mask = 4'hF; m_flags = 0; m_load = 0;
    for (int n = 0; n < 4; n++) begin m_adr[n] = 0; m_cnt[n] = 0; m_mode[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 mask", 64'(chan_mask), 64'hF);
    check("R1 load", 64'(chan_load), 0);
    check("R1 base", base_addr | base_count, 0);
    check("R1 mode", 64'(mode_cfg), 0);
    op(0, 1, 4'd8, 8'h00, 4'h0, "R1 status");
    op(0, 1, 4'd2, 8'h00, 4'h0, "R1 ptr low");
    op(1, 0, 4'd11, 8'h00, 4'h0, "R5 prep");

    // R2/R3 write 16-bit then read back
    op(1, 0, 4'd4, 8'h34, 4'h0, "R2 lo");
    op(1, 0, 4'd4, 8'h12, 4'h0, "R2 hi");
    check("R2 ch2 addr", 64'(base_addr[47:32]), 64'h1234);
    op(0, 1, 4'd4, 8'h00, 4'h0, "R3 lo");
    op(0, 1, 4'd4, 8'h00, 4'h0, "R3 hi");
    // R4 shared pointer: low byte to ch0 addr, then high byte lands in ch3 count
    op(1, 0, 4'd0, 8'hAA, 4'h0, "R4 a");
    op(1, 0, 4'd7, 8'hBB, 4'h0, "R4 b");
    check("R4 ch3 count hi", 64'(base_count[63:48]), 64'hBB00);
    // R5 clear pointer after one low write
    op(1, 0, 4'd1, 8'h55, 4'h0, "R5 lo");
    op(1, 0, 4'd11, 8'hFF, 4'h0, "R5 clr");
    op(1, 0, 4'd1, 8'h66, 4'h0, "R5 relo");
    check("R5 ch0 count", 64'(base_count[15:0]), 64'h0066);
    // R6 / R7 masks
    op(1, 0, 4'd12, 8'h00, 4'h0, "R7 clear all");
    op(1, 0, 4'd9, 8'h06, 4'h0, "R6 set ch2");
    check("R6 only ch2", 64'(chan_mask), 64'h4);
    op(1, 0, 4'd12, 8'hFF, 4'h0, "R7 mask all");
    check("R7 all", 64'(chan_mask), 64'hF);
    op(1, 0, 4'd9, 8'h01, 4'h0, "R6 clr ch1");
    check("R6 ch1 cleared", 64'(chan_mask), 64'hD);
    // R8 mode fields
    op(1, 0, 4'd10, 8'b01_0_1_10_11, 4'h0, "R8 ch3");
    check("R8 ch3 fields", 64'(mode_cfg[23:18]), 64'(6'b01_0_1_10));
    check("R8 others", 64'(mode_cfg[17:0]), 0);
    // R9 / R10 status
    op(0, 0, 4'd0, 8'h00, 4'h5, "R9 tc");
    op(0, 1, 4'd8, 8'h00, 4'h2, "R10 rd+tc");
    op(0, 1, 4'd8, 8'h00, 4'h0, "R10 kept");
    op(0, 1, 4'd8, 8'h00, 4'h0, "R10 empty");
    // R11 unmapped reads
    op(0, 1, 4'd13, 8'h00, 4'h0, "R11 13");
    op(0, 1, 4'd10, 8'h00, 4'h0, "R11 10");

    for (int i = 0; i < 600; i++) begin
      bit w;
      w = ($urandom % 2) == 0;
      v = 8'($urandom);
      op(w, !w, 4'($urandom % 16), v, (($urandom % 4) == 0) ? 4'($urandom) : 4'h0, "rand");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule